// File: doc/BRIEF.md
# Window Watchdog Reset Supervisor

This block is a clocked supervisor. It turns two supply-window comparator flags and a watchdog clear line into two outputs: an active-low reset and an active-low enable. The comparator flags arrive already digital and synchronous. The reset output drives an external open-drain pull-down: a low value means the pad is pulled low.

Reset stays asserted until the monitored input has sat inside the valid window (above the lower threshold, not above the upper one) for one full base period. Leaving the window in either direction asserts reset again and restarts that delay from zero.

Once reset is released, the block runs a windowed watchdog. Each period starts with a closed window, in which a clear is a fault. An open window follows, in which a clear is required. A fault in either window produces a short reset pulse, after which a fresh closed window begins. Every duration is a fixed ratio of one parameter, `BASE_TICKS`, which sets the base period in clock ticks.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first check after it goes low, `rst_out_n` is 0 and `en_out_n` is 1.
- R2: The input is in the window when `in_above_low`=1 and `in_above_high`=0. `rst_out_n` rises after exactly `BASE_TICKS` consecutive in-window clock edges following reset or a window exit.
- R3: `in_above_low`=0 drives `rst_out_n` low at the next clock edge. It also restarts the full power-on delay of R2.
- R4: `in_above_high`=1 drives `rst_out_n` low at the next clock edge. It also restarts the full power-on delay of R2.
- R5: The closed window lasts `BASE_TICKS*4/5` cycles. A clear rising edge that reaches the controller inside it starts a reset pulse.
- R6: The open window lasts `BASE_TICKS*2/5` cycles. If no clear edge arrives before it ends, a reset pulse starts.
- R7: A reset pulse holds `rst_out_n` low for `BASE_TICKS/40` cycles (at least 1). A new closed window follows the pulse.
- R8: A clear edge inside the open window restarts the closed window, and `rst_out_n` stays high.
- R9: `wd_clear` passes through a two-flop synchronizer and acts only on a 0-to-1 transition, two cycles after sampling. A level held high counts once.
- R10: `en_out_n` is low only while `rst_out_n` is high and the input is in the window. A window exit raises it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_above_low | input | 1 | 1 when the monitored input is above the lower threshold |
| in_above_high | input | 1 | 1 when the monitored input is above the upper threshold |
| wd_clear | input | 1 | Asynchronous watchdog clear request |
| rst_out_n | output | 1 | Active-low reset (0 = pull pad low) |
| en_out_n | output | 1 | Active-low enable |

## Verification
The assertions check, on every cycle, the following behaviours:
- a window exit forces reset low one edge later;
- reset rises only when the timer has just completed a full base period;
- a closed-window clear always yields reset while an open-window clear never does;
- the synchronized clear is a single-cycle pulse.

Some behaviours can only be shown by the bench's scenarios, compared cycle by cycle against its behavioural model:
- the exact window lengths;
- the pulse width;
- the restart of the delay after a brief dropout;
- the once-only effect of a held clear.

// File: rtl/sup_pkg.sv
// Shared types for the window watchdog supervisor.
// Assumes: none beyond a single clock domain.
package sup_pkg;
    typedef enum logic [1:0] {
        ST_POR    = 2'd0,
        ST_CLOSED = 2'd1,
        ST_OPEN   = 2'd2,
        ST_PULSE  = 2'd3
    } sup_state_t;
endpackage

// File: rtl/sup_clr_sync.sv
// Brings the asynchronous clear request into the clock domain and
// emits a one-cycle pulse on each 0-to-1 transition.
// Assumes: clear pulses are wider than two clock periods.
module sup_clr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_async,
    output logic clr_rise
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchronizer plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= clr_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising-edge pulse of the synchronized clear.
    assign clr_rise = sync_q & ~prev_q;

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> !clr_rise);
endmodule

// File: rtl/sup_timer.sv
// Shared up-counter for every supervisor interval; restart forces zero.
// Assumes: the controller restarts it before it can wrap.
module sup_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt
);
    // Count up each cycle, zero on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_supervisor.sv
// Window watchdog reset supervisor. Sequences a power-on delay from the
// supply-window flags, then enforces closed/open watchdog windows and
// issues a short reset pulse on any violation.
// Assumes: comparator flags are synchronous; BASE_TICKS >= 5.
module wdt_supervisor #(
    parameter int unsigned BASE_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_above_low,
    input  logic in_above_high,
    input  logic wd_clear,
    output logic rst_out_n,
    output logic en_out_n
);
    import sup_pkg::*;

    localparam int unsigned CLOSED_TICKS = BASE_TICKS * 4 / 5;
    localparam int unsigned OPEN_TICKS   = BASE_TICKS * 2 / 5;
    localparam int unsigned PULSE_TICKS  = (BASE_TICKS / 40 > 0) ? BASE_TICKS / 40 : 1;
    localparam int unsigned CW           = $clog2(BASE_TICKS + 1);
    localparam logic [CW-1:0] POR_LAST    = CW'(BASE_TICKS - 1);
    localparam logic [CW-1:0] CLOSED_LAST = CW'(CLOSED_TICKS - 1);
    localparam logic [CW-1:0] OPEN_LAST   = CW'(OPEN_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_TICKS - 1);

    sup_state_t    st_q;
    sup_state_t    st_d;
    logic          restart;
    logic          clr_rise;
    logic          in_win;
    logic [CW-1:0] tmr_cnt;

    assign in_win = in_above_low & ~in_above_high;

    sup_clr_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_async (wd_clear),
        .clr_rise  (clr_rise)
    );

    sup_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .cnt     (tmr_cnt)
    );

    // Next-state and timer-restart decision; window exit has top priority.
    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (!in_win) begin
            st_d    = ST_POR;
            restart = 1'b1;
        end else begin
            unique case (st_q)
                ST_POR: begin
                    if (tmr_cnt == POR_LAST) begin
                        st_d    = ST_CLOSED;
                        restart = 1'b1;
                    end
                end
                ST_CLOSED: begin
                    if (clr_rise) begin
                        st_d    = ST_PULSE;
                        restart = 1'b1;
                    end else if (tmr_cnt == CLOSED_LAST) begin
                        st_d    = ST_OPEN;
                        restart = 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (clr_rise) begin
                        st_d    = ST_CLOSED;
                        restart = 1'b1;
                    end else if (tmr_cnt == OPEN_LAST) begin
                        st_d    = ST_PULSE;
                        restart = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tmr_cnt == PULSE_LAST) begin
                        st_d    = ST_CLOSED;
                        restart = 1'b1;
                    end
                end
                default: begin
                    st_d    = ST_POR;
                    restart = 1'b1;
                end
            endcase
        end
    end

    // State register, held in the power-on state during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_POR;
        end else begin
            st_q <= st_d;
        end
    end

    // Reset is released only in the two watchdog windows.
    assign rst_out_n = (st_q == ST_CLOSED) || (st_q == ST_OPEN);
    // Enable follows released reset gated by the live window flag.
    assign en_out_n  = ~(rst_out_n & in_win);

    // R3 R4
    win_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> !rst_out_n);

    // R2
    por_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> ($past(tmr_cnt) == POR_LAST || $past(st_q) == ST_PULSE));

    // R5
    early_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CLOSED && clr_rise && in_win) |=> !rst_out_n);

    // R8
    open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && clr_rise && in_win) |=> (rst_out_n && tmr_cnt == '0));
endmodule

// File: tb/sim_wdt_supervisor.sv
module sim_wdt_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int BASE   = 200;
    localparam int CLOSED = BASE * 4 / 5;
    localparam int OPEN   = BASE * 2 / 5;
    localparam int PULSE  = (BASE / 40 > 0) ? BASE / 40 : 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo = 1'b0;
    logic hi = 1'b0;
    logic clr = 1'b0;
    logic rst_out_n;
    logic en_out_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_supervisor #(.BASE_TICKS(BASE)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_above_low  (lo),
        .in_above_high (hi),
        .wd_clear      (clr),
        .rst_out_n     (rst_out_n),
        .en_out_n      (en_out_n)
    );

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string tag = "R1";

    // Behavioural reference: mode 0 delay, 1 closed, 2 open, 3 pulse.
    int m_mode = 0;
    int m_t = 0;
    bit q[$] = '{1'b0, 1'b0, 1'b0};
    bit m_win;
    bit m_rise;

    always @(posedge clk) begin
        m_win = lo && !hi;
        if (!rst_n) begin
            m_mode = 0;
            m_t = 0;
            q = '{1'b0, 1'b0, 1'b0};
        end else begin
            m_rise = q[1] && !q[2];
            if (!m_win) begin
                m_mode = 0; m_t = 0;
            end else if (m_mode == 0) begin
                if (m_t == BASE - 1) begin m_mode = 1; m_t = 0; end else m_t++;
            end else if (m_mode == 1) begin
                if (m_rise) begin m_mode = 3; m_t = 0; end
                else if (m_t == CLOSED - 1) begin m_mode = 2; m_t = 0; end
                else m_t++;
            end else if (m_mode == 2) begin
                if (m_rise) begin m_mode = 1; m_t = 0; end
                else if (m_t == OPEN - 1) begin m_mode = 3; m_t = 0; end
                else m_t++;
            end else begin
                if (m_t == PULSE - 1) begin m_mode = 1; m_t = 0; end else m_t++;
            end
            q.push_front(clr);
            void'(q.pop_back());
        end
    end

    task automatic check();
        bit exp_rst;
        bit exp_en;
        exp_rst = (m_mode == 1) || (m_mode == 2);
        exp_en  = !(exp_rst && lo && !hi);
        compared++;
        if (rst_out_n !== exp_rst || en_out_n !== exp_en) begin
            mismatched++;
            $display("FAIL %s t=%0t rst_out_n=%0b exp %0b en_out_n=%0b exp %0b",
                     tag, $time, rst_out_n, exp_rst, en_out_n, exp_en);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check();
        end
    endtask

    task automatic pulse_clear();
        clr = 1'b1; step(3);
        clr = 1'b0; step(3);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog R1 cycles=%0d expected below %0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        // R1: reset state with supply in window
        tag = "R1"; lo = 1'b1; step(5);
        // R2: full power-on delay
        tag = "R2"; rst_n = 1'b1; step(BASE + 5);
        // R3: under-voltage, brief dropout restarts delay
        tag = "R3"; lo = 1'b0; step(3);
        lo = 1'b1; step(100);
        lo = 1'b0; step(2);
        lo = 1'b1; step(BASE + 3);
        // R4: over-voltage
        tag = "R4"; hi = 1'b1; step(4);
        hi = 1'b0; step(BASE + 2);
        // R8: clears in open window keep reset released
        tag = "R8"; step(CLOSED + 10); pulse_clear(); step(20);
        step(CLOSED - 20); pulse_clear(); step(10);
        // R5: early clear in closed window
        tag = "R5"; step(50); pulse_clear(); step(PULSE + 10);
        // R6: no clear, timeout
        tag = "R6"; step(CLOSED + OPEN + PULSE + 10);
        // R7: pulse width and following closed window
        tag = "R7"; step(CLOSED + OPEN + 2 * PULSE);
        // R9: held clear counts once
        tag = "R9"; clr = 1'b1; step(CLOSED + OPEN + 50);
        clr = 1'b0; step(10);
        // R10: combinational enable gating during the open window
        tag = "R10"; step(CLOSED + 10);
        hi = 1'b1; #1 check();
        step(2); hi = 1'b0; step(BASE + 5);
        // R1: reset applied mid-run
        tag = "R1"; rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(BASE + 5);
        finish_run();
    end
endmodule